// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block performs per-pin change detection for a 24-pin I/O expander arranged as three 8-bit ports. Every pad level passes through a synchroniser. Each pin then has its own trigger code, mask bit, polarity-inversion bit and capture-enable bit, which together decide when that pin's status bit is set. A single registered, active-low interrupt line tells the host that at least one unmasked pin has pending status. The configuration vectors come from the register file outside this block and arrive here as plain inputs.

The host works with three strobes. An input-register read returns one port's presented values. For pins that have capture enabled, this read also releases the held value and retires the pending status. A status read returns one port's status byte and has no side effect. A clear write retires status bits under a per-port byte enable. A separate live view gives the synchronised level of every pin at all times. The live view has no strobe and never changes any state.

Read responses come back on a one-cycle valid pulse with the data. There is no ready signal and no back-pressure: the host must accept every response in the cycle it appears. A read of port index 3, which does not exist, still produces a response, with zero data.

Top module: `gpint_ctrl`

## Requirements
- R1: The `live_o` vector equals the pad levels after two clock edges of synchronisation (a change set up before edge k is visible after edge k+1), with no inversion applied.
- R2: Trigger code 01 sets a pin's status on a rising synchronised level, 10 on a falling one, and 11 on either. In each case the status bit is visible one edge after the level appears on `live_o`.
- R3: Trigger code 00 (level) raises an event in every cycle in which the synchronised level differs from the pin's reference. The reference is the raw level last returned through an input-register read and is 0 after reset.
- R4: A pin whose mask bit is 1 never gets its status set. A mask bit of 0 enables that pin.
- R5: `irq_no` is a register. It is low exactly when, on the previous edge, some pin had status 1 and mask 0, and it follows mask changes one edge later.
- R6: When a capture-enabled, unmasked pin has an event and holds nothing, the block keeps the synchronised level. Input-register reads of that port return the held value instead of the live one until the hold is released.
- R7: A polarity bit of 1 inverts that pin's bit in input-register read data only. Status, edge detection and `live_o` do not see it.
- R8: An input-register read of port p releases the holds in port p, clears the status of capture-enabled pins in port p, and loads each reference with the raw value it returned. The status of pins without capture enabled is untouched.
- R9: A clear write with byte-enable bit p set clears the status of each pin in port p whose `clr_bits_i` bit is 1. An event on the same edge takes priority and keeps the status set.
- R10: A status read returns the port's status byte (bit b is pin 8p+b) and changes no state: a repeated read gives the same byte and `irq_no` is unchanged.
- R11: Every read strobe produces `rsp_vld_o` on the next cycle. If both strobes are high together, the input-register read is served. Port index 3 returns zero and has no side effect.
- R12: After reset all status, holds and references are 0, `irq_no` is high and `rsp_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 24 | Asynchronous pad levels, pin 8p+b is port p bit b |
| pol_inv_i | input | 24 | Per-pin read-data inversion |
| trig_i | input | 48 | Per-pin trigger code, pin i at bits 2i+1:2i |
| mask_i | input | 24 | Per-pin mask, 1 disables |
| latch_en_i | input | 24 | Per-pin capture enable |
| rd_port_i | input | 2 | Port selected by a read strobe |
| rd_in_i | input | 1 | Input-register read strobe |
| rd_sts_i | input | 1 | Status read strobe |
| clr_i | input | 1 | Clear write strobe |
| clr_be_i | input | 3 | Per-port byte enable of the clear write |
| clr_bits_i | input | 24 | Clear data, 1 clears the pin's status |
| rsp_vld_o | output | 1 | Read response valid, one cycle |
| rsp_data_o | output | 8 | Read response byte |
| live_o | output | 24 | Synchronised pad levels |
| irq_no | output | 1 | Active-low interrupt |

## Verification
A pad change set up before edge k reaches `live_o` after edge k+1, a pin's status after edge k+2, and `irq_no` after edge k+3. A strobe or clear write applied before edge e takes effect at e, its response is present after e, and its effect on `irq_no` shows after e+1. The bench drives inputs on the falling edge and keeps a cycle-accurate reference model that it advances on the rising edge. It compares every output at the following falling edge. Directed sequences count exactly these edges before each explicit check. Random stimulus then covers same-edge collisions such as an event meeting a clear.

// File: rtl/gpint_pkg.sv
package gpint_pkg;

  // Trigger code per pin; the encoding is decoded by the pin cell.
  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_FALL  = 2'b10,
    TRIG_ANY   = 2'b11
  } trig_e;

  localparam int unsigned TRIG_W = 2;

endpackage

// File: rtl/gpint_sync.sv
module gpint_sync #(
  parameter int unsigned WIDTH  = 24,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpint_pin.sv
module gpint_pin
  import gpint_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_i,      // synchronised level
  input  logic              pol_i,
  input  logic              mask_i,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic              latch_en_i,
  input  logic              rd_hit_i,   // input read of this pin's port
  input  logic              clr_hit_i,  // clear write aimed at this pin
  output logic              st_o,
  output logic              shown_o
);

  logic prev_q, ref_q, hold_q, held_q, st_q;
  logic fire, hit, held_after, capture, cur;

  // Event decode per trigger code
  always_comb begin
    unique case (trig_e'(trig_i))
      TRIG_LEVEL: fire = lvl_i ^ ref_q;
      TRIG_RISE:  fire = lvl_i & ~prev_q;
      TRIG_FALL:  fire = ~lvl_i & prev_q;
      default:    fire = lvl_i ^ prev_q;
    endcase
  end

  assign hit        = fire & ~mask_i;
  assign held_after = held_q & ~rd_hit_i;
  assign capture    = hit & latch_en_i & ~held_after;
  assign cur        = held_q ? hold_q : lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      ref_q  <= 1'b0;
      hold_q <= 1'b0;
      held_q <= 1'b0;
      st_q   <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (rd_hit_i) ref_q  <= cur;
      if (capture)  hold_q <= lvl_i;
      held_q <= held_after | capture;
      // a fresh event outranks every clear path
      st_q   <= hit | (st_q & ~clr_hit_i & ~(rd_hit_i & latch_en_i));
    end
  end

  assign st_o    = st_q;
  assign shown_o = cur ^ pol_i;

endmodule

// File: rtl/gpint_rd.sv
module gpint_rd #(
  parameter int unsigned NPORTS = 3,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned PSEL_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [PSEL_W-1:0]        port_i,
  input  logic                     rd_in_i,
  input  logic                     rd_sts_i,
  input  logic [NPORTS*PORT_W-1:0] shown_i,
  input  logic [NPORTS*PORT_W-1:0] st_i,
  output logic                     vld_o,
  output logic [PORT_W-1:0]        data_o
);

  logic [PORT_W-1:0] in_byte, st_byte;

  always_comb begin
    in_byte = '0;
    st_byte = '0;
    for (int p = 0; p < int'(NPORTS); p++) begin
      if (port_i == PSEL_W'(p)) begin
        in_byte = shown_i[p*PORT_W +: PORT_W];
        st_byte = st_i[p*PORT_W +: PORT_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      vld_o  <= rd_in_i | rd_sts_i;
      data_o <= rd_in_i ? in_byte : (rd_sts_i ? st_byte : '0);
    end
  end

endmodule

// File: rtl/gpint_ctrl.sv
module gpint_ctrl
  import gpint_pkg::*;
#(
  parameter int unsigned NPORTS      = 3,
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NPINS      = NPORTS * PORT_W,
  localparam int unsigned PSEL_W     = $clog2(NPORTS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NPINS-1:0]         pin_i,
  input  logic [NPINS-1:0]         pol_inv_i,
  input  logic [NPINS*TRIG_W-1:0]  trig_i,
  input  logic [NPINS-1:0]         mask_i,
  input  logic [NPINS-1:0]         latch_en_i,
  input  logic [PSEL_W-1:0]        rd_port_i,
  input  logic                     rd_in_i,
  input  logic                     rd_sts_i,
  input  logic                     clr_i,
  input  logic [NPORTS-1:0]        clr_be_i,
  input  logic [NPINS-1:0]         clr_bits_i,
  output logic                     rsp_vld_o,
  output logic [PORT_W-1:0]        rsp_data_o,
  output logic [NPINS-1:0]         live_o,
  output logic                     irq_no
);

  logic [NPINS-1:0]  lvl_w, st_w, shown_w;
  logic [NPORTS-1:0] rd_port_hit, clr_port_hit;
  logic              irq_nq;

  gpint_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (lvl_w)
  );

  // Port decode of the input read and of the clear write
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign rd_port_hit[p]  = rd_in_i & (rd_port_i == PSEL_W'(p));
    assign clr_port_hit[p] = clr_i & clr_be_i[p];
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    gpint_pin u_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lvl_i      (lvl_w[g]),
      .pol_i      (pol_inv_i[g]),
      .mask_i     (mask_i[g]),
      .trig_i     (trig_i[g*TRIG_W +: TRIG_W]),
      .latch_en_i (latch_en_i[g]),
      .rd_hit_i   (rd_port_hit[g / PORT_W]),
      .clr_hit_i  (clr_port_hit[g / PORT_W] & clr_bits_i[g]),
      .st_o       (st_w[g]),
      .shown_o    (shown_w[g])
    );
  end

  gpint_rd #(.NPORTS(NPORTS), .PORT_W(PORT_W), .PSEL_W(PSEL_W)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .port_i   (rd_port_i),
    .rd_in_i  (rd_in_i),
    .rd_sts_i (rd_sts_i),
    .shown_i  (shown_w),
    .st_i     (st_w),
    .vld_o    (rsp_vld_o),
    .data_o   (rsp_data_o)
  );

  // Registered so the host line never glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_nq <= 1'b1;
    else         irq_nq <= ~|(st_w & ~mask_i);
  end

  assign irq_no = irq_nq;
  assign live_o = lvl_w;

endmodule

// File: rtl/gpint_chk.sv
module gpint_chk #(
  parameter int unsigned NPORTS      = 3,
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NPINS      = NPORTS * PORT_W,
  localparam int unsigned PSEL_W     = $clog2(NPORTS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NPINS-1:0]  pin_i,
  input logic [NPINS-1:0]  mask_i,
  input logic [NPINS-1:0]  latch_en_i,
  input logic [PSEL_W-1:0] rd_port_i,
  input logic              rd_in_i,
  input logic              rd_sts_i,
  input logic              clr_i,
  input logic [NPORTS-1:0] clr_be_i,
  input logic [NPINS-1:0]  clr_bits_i,
  input logic              rsp_vld_o,
  input logic [NPINS-1:0]  live_o,
  input logic              irq_no,
  input logic [NPINS-1:0]  st_i
);

  logic [1:0]       cyc_q;
  logic [NPINS-1:0] may_drop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  // Bits that a clear write or an input read may retire this cycle
  for (genvar g = 0; g < NPINS; g++) begin : g_drop
    assign may_drop[g] = (clr_i & clr_be_i[g / PORT_W] & clr_bits_i[g]) |
                         (rd_in_i & (rd_port_i == PSEL_W'(g / PORT_W)) & latch_en_i[g]);
  end

  if (SYNC_STAGES == 2) begin : g_sync_chk
    // R1
    p_live_sync_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q >= 2'd2) |-> (live_o == $past(pin_i, 2)));
  end

  // R4
  p_mask_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_i & ~$past(st_i) & $past(mask_i)) == '0));

  // R5
  p_irq_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == ~|($past(st_i) & ~$past(mask_i)));

  // R8 and R9: status only falls through a clear path
  p_drop_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~st_i & $past(st_i) & ~$past(may_drop)) == '0));

  // R11
  p_rsp_next_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1) |-> (rsp_vld_o == $past(rd_in_i | rd_sts_i)));

endmodule

bind gpint_ctrl gpint_chk #(
  .NPORTS      (NPORTS),
  .PORT_W      (PORT_W),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pin_i      (pin_i),
  .mask_i     (mask_i),
  .latch_en_i (latch_en_i),
  .rd_port_i  (rd_port_i),
  .rd_in_i    (rd_in_i),
  .rd_sts_i   (rd_sts_i),
  .clr_i      (clr_i),
  .clr_be_i   (clr_be_i),
  .clr_bits_i (clr_bits_i),
  .rsp_vld_o  (rsp_vld_o),
  .live_o     (live_o),
  .irq_no     (irq_no),
  .st_i       (st_w)
);

// File: tb/tb_gpint_ctrl.sv
`timescale 1ns/1ps
module tb_gpint_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pin = '0, pol = '0, mask = '1, len = '0, clr_bits = '0;
  logic [47:0] trig = '0;
  logic [1:0]  port = '0;
  logic        rd_in = 1'b0, rd_sts = 1'b0, clr = 1'b0;
  logic [2:0]  clr_be = '0;
  logic        rsp_vld, irq_n;
  logic [7:0]  rsp_data;
  logic [23:0] live;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gpint_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .pol_inv_i(pol), .trig_i(trig),
    .mask_i(mask), .latch_en_i(len), .rd_port_i(port), .rd_in_i(rd_in),
    .rd_sts_i(rd_sts), .clr_i(clr), .clr_be_i(clr_be), .clr_bits_i(clr_bits),
    .rsp_vld_o(rsp_vld), .rsp_data_o(rsp_data), .live_o(live), .irq_no(irq_n)
  );

  // ---------------- reference model from the requirements ----------------
  logic [23:0] m_f1, m_s, m_p, m_ref, m_hold, m_held, m_st;
  logic        m_irqn, m_vld;
  logic [7:0]  m_data;
  logic [23:0] t_ev, t_rdm, t_clrm, t_cur, t_ha, t_cap;

  function automatic logic f_ev(logic s, logic p, logic r, logic [1:0] t);
    case (t)
      2'b00:   return s ^ r;
      2'b01:   return s & ~p;
      2'b10:   return ~s & p;
      default: return s ^ p;
    endcase
  endfunction

  function automatic logic [23:0] f_pmask(logic [1:0] p);
    return (p == 2'd3) ? 24'h0 : (24'hFF << (8 * p));
  endfunction

  function automatic logic [7:0] f_byte(logic [23:0] v, logic [1:0] p);
    return (p == 2'd3) ? 8'h00 : v[8*p +: 8];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_f1 <= '0; m_s <= '0; m_p <= '0; m_ref <= '0; m_hold <= '0;
      m_held <= '0; m_st <= '0; m_irqn <= 1'b1; m_vld <= 1'b0; m_data <= '0;
    end else begin
      for (int i = 0; i < 24; i++)
        t_ev[i] = ~mask[i] & f_ev(m_s[i], m_p[i], m_ref[i], trig[2*i +: 2]);
      t_rdm  = rd_in ? f_pmask(port) : 24'h0;
      t_clrm = clr ? ({{8{clr_be[2]}}, {8{clr_be[1]}}, {8{clr_be[0]}}} & clr_bits) : 24'h0;
      t_cur  = (m_held & m_hold) | (~m_held & m_s);
      t_ha   = m_held & ~t_rdm;
      t_cap  = t_ev & len & ~t_ha;
      m_f1   <= pin;
      m_s    <= m_f1;
      m_p    <= m_s;
      m_ref  <= (t_rdm & t_cur) | (~t_rdm & m_ref);
      m_hold <= (t_cap & m_s) | (~t_cap & m_hold);
      m_held <= t_ha | t_cap;
      m_st   <= t_ev | (m_st & ~t_clrm & ~(t_rdm & len));
      m_irqn <= ~|(m_st & ~mask);
      m_vld  <= rd_in | rd_sts;
      m_data <= rd_in ? f_byte(t_cur ^ pol, port) : (rd_sts ? f_byte(m_st, port) : 8'h00);
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R5 irq_no vs model", 32'(irq_n), 32'(m_irqn));
    chk("R1 live vs model", 32'(live), 32'(m_s));
    chk("R11 rsp_vld vs model", 32'(rsp_vld), 32'(m_vld));
    if (m_vld) chk("R6 R8 R10 rsp_data vs model", 32'(rsp_data), 32'(m_data));
  endtask

  task automatic wait_n(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic do_read(bit inreg, logic [1:0] p, output logic [7:0] d);
    port = p; rd_in = inreg; rd_sts = ~inreg;
    tick();
    rd_in = 1'b0; rd_sts = 1'b0;
    d = rsp_data;
  endtask

  task automatic do_clear(logic [2:0] be, logic [23:0] bits);
    clr = 1'b1; clr_be = be; clr_bits = bits;
    tick();
    clr = 1'b0; clr_be = '0; clr_bits = '0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] d;
    int unsigned seed;
    seed = $urandom(32'h1C0FFEE);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 irq_no high after reset", 32'(irq_n), 32'd1);
    chk("R12 rsp_vld low after reset", 32'(rsp_vld), 32'd0);
    chk("R12 live zero after reset", 32'(live), 32'd0);

    // R2 rising edge on pin 3 (port 0 bit 3)
    mask[3] = 1'b0; trig[7:6] = 2'b01; pin[3] = 1'b1;
    wait_n(4);
    chk("R2 rising edge raises irq", 32'(irq_n), 32'd0);
    do_read(1'b0, 2'd0, d);
    chk("R10 status byte port0", 32'(d), 32'h08);
    do_read(1'b0, 2'd0, d);
    chk("R10 repeated status read unchanged", 32'(d), 32'h08);
    chk("R10 irq unchanged by status read", 32'(irq_n), 32'd0);
    do_clear(3'b001, 24'h000008);
    tick();
    chk("R9 clear releases irq", 32'(irq_n), 32'd1);
    do_read(1'b0, 2'd0, d);
    chk("R9 status cleared", 32'(d), 32'h00);

    // R4 masked any-edge pin
    mask[3] = 1'b1; trig[7:6] = 2'b11; pin[3] = 1'b0;
    wait_n(4);
    do_read(1'b0, 2'd0, d);
    chk("R4 masked pin keeps status 0", 32'(d), 32'h00);
    chk("R4 masked pin leaves irq high", 32'(irq_n), 32'd1);

    // R5 mask toggling with pending status
    trig[7:6] = 2'b01; mask[3] = 1'b0; pin[3] = 1'b1;
    wait_n(4);
    mask[3] = 1'b1;
    tick();
    chk("R5 masking pending status releases irq", 32'(irq_n), 32'd1);
    mask[3] = 1'b0;
    tick();
    chk("R5 unmasking pending status asserts irq", 32'(irq_n), 32'd0);
    do_clear(3'b001, 24'h000008);
    tick();

    // R3 level mode on pin 12 (port 1 bit 4)
    mask[12] = 1'b0; trig[25:24] = 2'b00; pin[12] = 1'b1;
    wait_n(4);
    chk("R3 level mismatch raises irq", 32'(irq_n), 32'd0);
    do_read(1'b1, 2'd1, d);
    chk("R3 input read returns level", 32'(d), 32'h10);
    do_clear(3'b010, 24'h001000);
    wait_n(3);
    do_read(1'b0, 2'd1, d);
    chk("R3 level matches reference, no new event", 32'(d), 32'h00);
    chk("R3 irq stays released", 32'(irq_n), 32'd1);

    // R6 / R8 capture on pin 10 (port 1 bit 2)
    len[10] = 1'b1; mask[10] = 1'b0; trig[21:20] = 2'b01; pin[10] = 1'b1;
    wait_n(4);
    pin[10] = 1'b0;
    wait_n(4);
    chk("R1 live shows low level of held pin", 32'(live[10]), 32'd0);
    do_read(1'b1, 2'd1, d);
    chk("R6 input read returns held value", 32'(d), 32'h14);
    tick();
    chk("R8 input read retires capture-enabled status", 32'(irq_n), 32'd1);
    do_read(1'b0, 2'd1, d);
    chk("R8 status port1 cleared by input read", 32'(d), 32'h00);
    do_read(1'b1, 2'd1, d);
    chk("R8 hold released, live value returned", 32'(d), 32'h10);

    // R7 polarity on pin 20 (port 2 bit 4)
    pol[20] = 1'b1;
    do_read(1'b1, 2'd2, d);
    chk("R7 inverted read data", 32'(d), 32'h10);
    chk("R7 live not inverted", 32'(live[20]), 32'd0);

    // R11 both strobes, absent port
    port = 2'd3; rd_in = 1'b1; rd_sts = 1'b1;
    tick();
    rd_in = 1'b0; rd_sts = 1'b0;
    chk("R11 port 3 response valid", 32'(rsp_vld), 32'd1);
    chk("R11 port 3 returns zero", 32'(rsp_data), 32'd0);

    // Random phase, checked against the model on every cycle
    for (int c = 0; c < 6000; c++) begin
      if (c % 97 == 0) begin
        mask = 24'($urandom) | 24'($urandom);
        trig = {16'($urandom), 32'($urandom)};
        len  = 24'($urandom);
        pol  = 24'($urandom);
      end
      pin    = pin ^ (24'($urandom) & 24'($urandom) & 24'($urandom));
      port   = 2'($urandom);
      rd_in  = ($urandom % 8) == 0;
      rd_sts = ($urandom % 8) == 0;
      clr    = ($urandom % 6) == 0;
      clr_be = 3'($urandom);
      clr_bits = 24'($urandom);
      tick();
    end
    rd_in = 1'b0; rd_sts = 1'b0; clr = 1'b0;
    tick();
    summary();
  end

endmodule